// File: doc/BRIEF.md
# Conditional Pulse Steering Module

This block is the hardware form of a two-way branch in a control flow built from pulse-driven stages. Several active-low entry lines feed it. A low pulse on any of them means that control has reached the branch. The block then sends exactly one active-low pulse out on one of two exit lines. A single condition bit, settled before the entry pulse arrives, picks the exit line.

Both exit lines use the same active-low pulse form as the entry lines. An exit can therefore drive a task stage or another steering block directly. Any compound decision is reduced to one bit before it reaches the condition input.

The block is synchronous. An entry is recognised at the first rising clock edge at which any entry line is sampled low after all lines were high. The chosen exit is low for the whole following clock cycle. An active-low synchronous clear returns the block to idle.

Top module: `cond_pulse_steer`

## Requirements
- R1: The entry lines are merged. A low level on any one line, or on several at once, counts as one entry. With the default of three lines, each line alone produces an exit pulse.
- R2: When an entry is detected at an edge and the condition bit is 1 at that edge, `take_one_n` is low for exactly the one clock cycle after that edge.
- R3: When an entry is detected at an edge and the condition bit is 0 at that edge, `take_zero_n` is low for exactly the one clock cycle after that edge.
- R4: The condition bit is sampled only at the detection edge. Changing it while the entry lines stay low neither redirects the exit pulse nor adds a pulse.
- R5: Each entry gives one exit pulse, however long the entry lines stay low. A second line that goes low while another is still low does not start a new entry.
- R6: The two exit lines are never low in the same cycle. Both are high whenever no exit pulse is due.
- R7: While `rst_n` is low, both exit lines are high from the next edge on, and no entry is recognised. An entry line that is still low when the clear is released is not counted. It is counted only after all entry lines have returned high and one goes low again.
- R8: One clock cycle with all entry lines high between two low periods is enough to make them two entries, giving two exit pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous common clear |
| enter_n | input | N_IN | Active-low entry pulse lines, merged |
| cond | input | 1 | Branch condition bit, settled before the entry pulse |
| take_one_n | output | 1 | Active-low exit pulse taken when the condition is 1 |
| take_zero_n | output | 1 | Active-low exit pulse taken when the condition is 0 |

## Verification
The states that are hardest to reach from the ports are entries that overlap, or that span a clear. These are a second line going low while the first is still low, the condition bit flipping in the middle of a long pulse, and an entry line held low across the release of the clear. The stimulus builds each case directly. It staggers the low periods of two lines, toggles the condition on every cycle of a five-cycle pulse, and keeps a line low through and past the clear. It then checks that the pulse counts on each exit line did not move. A behavioural model run on every clock compares both exit lines, so a misplaced or extra pulse is also caught in the cycle where it occurs.

// File: rtl/steer_pkg.sv
// Package: shared types and helpers for the conditional pulse steering block.
// Assumes all control lines are active low and idle high.
package steer_pkg;

    // Branch selected by the condition bit.
    typedef enum logic {
        BR_ZERO = 1'b0,
        BR_ONE  = 1'b1
    } branch_e;

    // Exit line levels {one_n, zero_n} for a given start strobe and branch.
    function automatic logic [1:0] exit_levels(input logic start, input branch_e br);
        logic [1:0] lv;
        lv = 2'b11;
        if (start) begin
            if (br == BR_ONE) lv[1] = 1'b0;
            else              lv[0] = 1'b0;
        end
        return lv;
    endfunction

endpackage

// File: rtl/steer_merge.sv
// Module: steer_merge
// Merges N_IN active-low entry lines into one active-high "entry active" level.
// Assumes the lines are already synchronous to the block clock.
module steer_merge #(
    parameter int N_IN = 3
) (
    input  logic [N_IN-1:0] enter_n,
    output logic            any_active
);
    localparam int CHAIN = N_IN + 1;

    logic [CHAIN-1:0] chain;

    assign chain[0] = 1'b0;

    // OR chain across the inverted entry lines.
    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_or
            assign chain[i+1] = chain[i] | ~enter_n[i];
        end
    endgenerate

    assign any_active = chain[CHAIN-1];

endmodule

// File: rtl/steer_entry_detect.sv
// Module: steer_entry_detect
// Produces a one-cycle start strobe on the first cycle the merged entry level is
// seen active after being idle. Clear leaves it "seen active", so a line held low
// across the clear release is not counted.
module steer_entry_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic any_active,
    output logic start
);
    logic was_active;

    // Remember last cycle's merged level; clear forces the "active" memory.
    always_ff @(posedge clk) begin
        if (!rst_n) was_active <= 1'b1;
        else        was_active <= any_active;
    end

    assign start = any_active & ~was_active;

    // R5: a start strobe is never followed by another start in the next cycle.
    assert_single_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

endmodule

// File: rtl/steer_route.sv
// Module: steer_route
// Samples the condition bit at the start strobe and drives the selected active-low
// exit for one cycle. Assumes the condition is settled when start is high.
module steer_route
    import steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cond,
    output logic take_one_n,
    output logic take_zero_n
);
    logic [1:0] next_lv;

    // Levels for the next cycle from the strobe and the sampled condition.
    always_comb begin
        next_lv = exit_levels(start, branch_e'(cond));
    end

    // Exit registers; clear holds both lines high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_one_n  <= 1'b1;
            take_zero_n <= 1'b1;
        end else begin
            take_one_n  <= next_lv[1];
            take_zero_n <= next_lv[0];
        end
    end

    // R2: start with condition 1 drives the one-exit low next cycle.
    assert_route_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cond) |=> !take_one_n);
    // R2: the one-exit pulse lasts a single cycle.
    assert_one_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !take_one_n |=> take_one_n);
    // R3: start with condition 0 drives the zero-exit low next cycle.
    assert_route_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cond) |=> !take_zero_n);
    // R3: the zero-exit pulse lasts a single cycle.
    assert_zero_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !take_zero_n |=> take_zero_n);
    // R6: exits never low together.
    assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!take_one_n && !take_zero_n));
    // R7: after a clear edge both exits are high.
    assert_clear_idle_R7: assert property (@(posedge clk)
        !rst_n |=> (take_one_n && take_zero_n));

endmodule

// File: rtl/cond_pulse_steer.sv
// Module: cond_pulse_steer (top)
// Two-way pulse steering: merges N_IN active-low entry lines and sends one
// active-low one-cycle pulse to the exit chosen by cond. Assumes cond is settled
// when the entry is sampled and the entry lines are synchronous to clk.
module cond_pulse_steer #(
    parameter int N_IN = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] enter_n,
    input  logic            cond,
    output logic            take_one_n,
    output logic            take_zero_n
);
    logic any_active;
    logic start;

    steer_merge #(.N_IN(N_IN)) u_merge (
        .enter_n    (enter_n),
        .any_active (any_active)
    );

    steer_entry_detect u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_active (any_active),
        .start      (start)
    );

    steer_route u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cond        (cond),
        .take_one_n  (take_one_n),
        .take_zero_n (take_zero_n)
    );

    // R1: any low entry line right after all-idle yields a start.
    assert_merge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(&enter_n) && !(&enter_n)) |-> start);
    // R4: an exit pulse only follows a start strobe.
    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_one_n || !take_zero_n) |-> $past(start));

endmodule

// File: tb/cond_pulse_steer_tb.sv
`timescale 1ns/1ps
module cond_pulse_steer_tb;
    localparam int N_IN = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N_IN-1:0] enter_n = '1;
    logic            cond = 1'b0;
    logic            take_one_n;
    logic            take_zero_n;

    int checks = 0;
    int fails  = 0;
    int cnt_one = 0;
    int cnt_zero = 0;
    bit done = 1'b0;

    // Reference model state
    bit m_prev = 1'b1;
    bit e_one = 1'b1;
    bit e_zero = 1'b1;

    always #4 clk = ~clk;

    cond_pulse_steer #(.N_IN(N_IN)) u_dut (
        .clk(clk), .rst_n(rst_n), .enter_n(enter_n), .cond(cond),
        .take_one_n(take_one_n), .take_zero_n(take_zero_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model, compared on every clock.
    always @(posedge clk) begin
        bit any_low;
        bit st;
        any_low = (enter_n != '1);
        if (!rst_n) begin
            e_one = 1'b1; e_zero = 1'b1; m_prev = 1'b1;
        end else begin
            st = any_low && !m_prev;
            e_one  = !(st && cond);
            e_zero = !(st && !cond);
            m_prev = any_low;
        end
        #2;
        check(take_one_n === e_one,  "R2 one-exit per cycle", int'(take_one_n), int'(e_one));
        check(take_zero_n === e_zero, "R3 zero-exit per cycle", int'(take_zero_n), int'(e_zero));
        check(!(take_one_n === 1'b0 && take_zero_n === 1'b0), "R6 exclusive", 0, 1);
        if (take_one_n === 1'b0) cnt_one++;
        if (take_zero_n === 1'b0) cnt_zero++;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_counts(input string tag, input int d1, input int d0,
                                 input int b1, input int b0);
        cyc(3);
        check(cnt_one == b1 + d1, tag, cnt_one - b1, d1);
        check(cnt_zero == b0 + d0, tag, cnt_zero - b0, d0);
    endtask

    initial begin
        int b1;
        int b0;
        cyc(3);
        check(take_one_n === 1'b1 && take_zero_n === 1'b1, "R7 reset state",
              int'({take_one_n, take_zero_n}), 3);
        rst_n = 1'b1;
        cyc(2);

        // R2: single line, condition 1
        b1 = cnt_one; b0 = cnt_zero;
        cond = 1'b1; enter_n = 3'b110; cyc(1); enter_n = '1;
        expect_counts("R2 cond=1 one pulse", 1, 0, b1, b0);

        // R1 and R3: each line alone, condition 0
        for (int i = 0; i < N_IN; i++) begin
            b1 = cnt_one; b0 = cnt_zero;
            cond = 1'b0; enter_n = '1; enter_n[i] = 1'b0; cyc(2); enter_n = '1;
            expect_counts("R1 R3 per-line zero exit", 0, 1, b1, b0);
        end

        // R1: all lines together
        b1 = cnt_one; b0 = cnt_zero;
        cond = 1'b1; enter_n = '0; cyc(1); enter_n = '1;
        expect_counts("R1 all lines one entry", 1, 0, b1, b0);

        // R4: condition toggles during a long pulse
        b1 = cnt_one; b0 = cnt_zero;
        cond = 1'b0; enter_n = 3'b011;
        for (int k = 0; k < 5; k++) begin cyc(1); cond = ~cond; end
        enter_n = '1;
        expect_counts("R4 cond sampled once", 0, 1, b1, b0);

        // R5: overlapping low periods on two lines
        b1 = cnt_one; b0 = cnt_zero;
        cond = 1'b1; enter_n = 3'b110; cyc(2);
        enter_n = 3'b100; cyc(1);
        enter_n = 3'b101; cyc(3);
        enter_n = '1;
        expect_counts("R5 overlap single pulse", 1, 0, b1, b0);

        // R8: one idle cycle separates two entries
        b1 = cnt_one; b0 = cnt_zero;
        cond = 1'b0; enter_n = 3'b101; cyc(1);
        enter_n = '1; cyc(1);
        cond = 1'b1; enter_n = 3'b101; cyc(1);
        enter_n = '1;
        expect_counts("R8 back-to-back", 1, 1, b1, b0);

        // R7: line held low across clear is not counted
        b1 = cnt_one; b0 = cnt_zero;
        rst_n = 1'b0; cond = 1'b1; enter_n = 3'b110; cyc(2);
        rst_n = 1'b1; cyc(4);
        check(take_one_n === 1'b1 && take_zero_n === 1'b1, "R7 held line after clear",
              int'({take_one_n, take_zero_n}), 3);
        enter_n = '1;
        expect_counts("R7 no pulse across clear", 0, 0, b1, b0);
        b1 = cnt_one; b0 = cnt_zero;
        enter_n = 3'b110; cyc(1); enter_n = '1;
        expect_counts("R7 entry counted after idle", 1, 0, b1, b0);

        // R7: clear asserted in the cycle an entry arrives
        b1 = cnt_one; b0 = cnt_zero;
        rst_n = 1'b0; cond = 1'b0; enter_n = 3'b011; cyc(1);
        enter_n = '1; cyc(1); rst_n = 1'b1;
        expect_counts("R7 entry during clear dropped", 0, 0, b1, b0);

        cyc(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule